// File: doc/BRIEF.md
# Dithered 14-bit Tuning PWM

This block produces one pulse-width-modulated line. Through an external low-pass filter it acts as a digital-to-analog converter for a tuning voltage. The coarse duty comes from an 8-bit base counter that runs without stopping, compared against an 8-bit coarse value. A 6-bit frame counter spans 64 PWM cycles. In some of those cycles it stretches the high phase by one extra tick, so the average duty over a frame has 14 bits of resolution.

The counters only advance on clocks where the `tick` enable from an upstream prescaler is high. Software loads the coarse and fine values through a valid/ready write port into shadow registers. `wr_ready` is always high, so a write completes on any clock where `wr_valid` is high, and no back-pressure is ever applied. A clock with `wr_valid` low writes nothing. The block raises a one-clock pulse at the end of every frame. A mode pin turns off the fine extension, which gives a plain 8-bit PWM. A standby pin freezes the block and forces the output low.

Top module: `tuning_pwm14`

## Requirements
- R1: After reset, `pwm_out` and `frame_irq` are low and `wr_ready` is high. The base counter, the frame counter and both active values start at zero.
- R2: The base counter position (0..255) advances by one on each clock where `tick` is high and `standby` is low, and wraps from 255 to 0. On any other clock it holds, so one PWM cycle lasts 256 ticks.
- R3: Within a PWM cycle, `pwm_out` is high at position p exactly when p < D + E. Here D is the active coarse value and E is 1 for a stretched cycle and 0 otherwise. D=0 with E=0 keeps the cycle fully low, and D=255 with E=1 keeps it fully high.
- R4: A write with `wr_sel`=0 stores `wr_data` as the coarse value. That value becomes active at the next wrap of the base counter from 255 to 0.
- R5: A write with `wr_sel`=1 stores `wr_data[5:0]` as the fine value N. That value becomes active only at the wrap that ends frame cycle 63, so one frame never uses two fine values.
- R6: Cycle k of a frame (k = 0..63) is stretched exactly when the 6-bit bit-reversal of k is less than N. This gives exactly N stretched cycles per frame, spread across the frame, and 64·D + N high ticks per frame.
- R7: `frame_irq` is high for exactly one clock, namely the clock right after the tick that ends frame cycle 63.
- R8: While `plain8` is high, no cycle is stretched, so each frame has 64·D high ticks.
- R9: While `standby` is high, `pwm_out` is low, both counters hold and `frame_irq` stays low. Writes are still accepted. When standby ends, counting resumes from the held position.
- R10: `wr_ready` is always high, and a clock with `wr_valid` low changes neither shadow value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accept, always high |
| wr_sel | input | 1 | 0 = coarse value, 1 = fine value |
| wr_data | input | 8 | Write data (fine value uses bits 5:0) |
| plain8 | input | 1 | Turns off the fine extension |
| standby | input | 1 | Freeze the counters and force the output low |
| pwm_out | output | 1 | PWM output |
| frame_irq | output | 1 | One-clock pulse at the end of each frame |

## Verification
The assertions check the following on every clock:
- the base counter steps by one on an enabled tick and holds otherwise;
- the coarse value changes only after a wrap;
- the fine value changes only after a frame end;
- the interrupt lasts one clock and never follows a standby clock.

Some behaviour only the bench scenarios can show: the exact high time per frame (64·D + N), how the stretches are placed by bit-reversal, the extreme duty values, and the absence of stretching in plain mode. They also cover writes that are ignored and resuming after standby. A behavioural model compared on every clock checks all of these.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  typedef enum logic {
    SEL_COARSE = 1'b0,
    SEL_FINE   = 1'b1
  } tpwm_sel_e;
endpackage

// File: rtl/tpwm_wr_regs.sv
module tpwm_wr_regs #(
  parameter int CW = 8,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] coarse_sh,
  output logic [FW-1:0] fine_sh
);
  import tpwm_pkg::*;

  tpwm_sel_e sel;
  assign sel = tpwm_sel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse_sh <= '0;
      fine_sh   <= '0;
    end else if (wr_fire) begin
      if (sel == SEL_COARSE) coarse_sh <= wr_data;
      else                   fine_sh   <= wr_data[FW-1:0];
    end
  end
endmodule

// File: rtl/tpwm_base.sv
module tpwm_base #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [CW-1:0] coarse_sh,
  input  logic          ext,
  output logic          wrap,
  output logic          level
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cmp_q;
  logic [CW:0]   limit;

  assign wrap  = adv && (cnt_q == {CW{1'b1}});
  assign limit = {1'b0, cmp_q} + {{CW{1'b0}}, ext};
  assign level = ({1'b0, cnt_q} < limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap) cmp_q <= coarse_sh;
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> cnt_q == $past(cnt_q) + 1'b1);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q));
  // R4
  cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_q) |-> $past(wrap));
endmodule

// File: rtl/tpwm_frame.sv
module tpwm_frame #(
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap,
  input  logic          plain8,
  input  logic [FW-1:0] fine_sh,
  output logic          ext,
  output logic          irq
);
  logic [FW-1:0] fcnt_q;
  logic [FW-1:0] fine_q;
  logic [FW-1:0] rev;
  logic          frame_end;

  for (genvar i = 0; i < FW; i++) begin : g_rev
    assign rev[i] = fcnt_q[FW-1-i];
  end

  assign frame_end = wrap && (fcnt_q == {FW{1'b1}});
  assign ext       = !plain8 && (rev < fine_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      fine_q <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= frame_end;
      if (wrap) fcnt_q <= fcnt_q + 1'b1;
      if (frame_end) fine_q <= fine_sh;
    end
  end

  // R5
  fine_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fine_q) |-> $past(frame_end));
  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/tuning_pwm14.sv
module tuning_pwm14 #(
  parameter int CW = 8,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          plain8,
  input  logic          standby,
  output logic          pwm_out,
  output logic          frame_irq
);
  logic          adv, wrap, ext, level;
  logic [CW-1:0] coarse_sh;
  logic [FW-1:0] fine_sh;

  assign wr_ready = 1'b1;
  assign adv      = tick && !standby;

  tpwm_wr_regs #(.CW(CW), .FW(FW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_valid && wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data),
    .coarse_sh(coarse_sh), .fine_sh(fine_sh));

  tpwm_base #(.CW(CW)) u_base (
    .clk(clk), .rst_n(rst_n), .adv(adv), .coarse_sh(coarse_sh),
    .ext(ext), .wrap(wrap), .level(level));

  tpwm_frame #(.FW(FW)) u_frame (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .plain8(plain8),
    .fine_sh(fine_sh), .ext(ext), .irq(frame_irq));

  assign pwm_out = level && !standby;

  // R9
  standby_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !frame_irq);
endmodule

// File: tb/tuning_pwm14_tb.sv
module tuning_pwm14_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, wr_valid = 0, wr_sel = 0;
  logic plain8 = 0, standby = 0, slow = 0;
  logic [7:0] wr_data = 0;
  logic wr_ready, pwm_out, frame_irq;
  int compared = 0, mismatched = 0;
  int m_cnt, m_frame, m_duty, m_fine, m_hi, m_lo, m_irq, tdiv;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  tuning_pwm14 dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_sel(wr_sel), .wr_data(wr_data), .plain8(plain8),
    .standby(standby), .pwm_out(pwm_out), .frame_irq(frame_irq));

  function automatic int brev6(int k);
    int r = 0;
    for (int i = 0; i < 6; i++) if (k & (1 << i)) r |= 1 << (5 - i);
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_frame = 0; m_duty = 0; m_fine = 0; m_hi = 0; m_lo = 0; m_irq = 0;
    end else begin
      m_irq = 0;
      if (tick && !standby) begin
        if (m_cnt == 255) begin
          m_cnt = 0; m_duty = m_hi;
          if (m_frame == 63) begin m_fine = m_lo; m_irq = 1; end
          m_frame = (m_frame + 1) % 64;
        end else m_cnt++;
      end
      if (wr_valid) begin
        if (wr_sel) m_lo = wr_data & 63; else m_hi = wr_data;
      end
    end
  end

  // per-clock comparison (R3 R6 R7 R8 R9 R10)
  always @(negedge clk) if (cmp_on) begin
    int e;
    e = (!plain8 && brev6(m_frame) < m_fine) ? 1 : 0;
    chk("R3/R6 pwm_out", pwm_out, (!standby && m_cnt < m_duty + e) ? 1 : 0);
    chk("R7 frame_irq", frame_irq, m_irq);
    chk("R10 wr_ready", wr_ready, 1);
  end

  // tick driver (R2)
  always begin
    @(posedge clk); #2;
    tdiv = (tdiv + 1) % 3;
    tick <= slow ? (tdiv == 0) : 1'b1;
  end

  task automatic wr(bit sel, int d);
    @(posedge clk); #2; wr_valid = 1; wr_sel = sel; wr_data = d[7:0];
    @(posedge clk); #2; wr_valid = 0;
  endtask

  task automatic wait_irq();
    do @(negedge clk); while (!frame_irq);
  endtask

  task automatic measure(string req, int expv);
    int hc = 0;
    wait_irq();
    for (int i = 0; i < 16384; i++) begin
      if (i != 0) @(negedge clk);
      hc += pwm_out;
    end
    chk(req, hc, expv);
  endtask

  initial begin
    tdiv = 0;
    repeat (3) @(posedge clk);
    #2;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm_out reset", pwm_out, 0);
    chk("R1 frame_irq reset", frame_irq, 0);
    chk("R1 wr_ready reset", wr_ready, 1);
    @(posedge clk); #2; rst_n = 1; cmp_on = 1;
    // R4 R5 R6: 64*100+37
    wr(0, 100); wr(1, 37);
    measure("R6 frame high ticks D=100 N=37", 6437);
    // R3 extremes: full high
    @(posedge clk); #2;
    wr(0, 255); wr(1, 63);
    measure("R3 frame high ticks D=255 N=63", 16383);
    // R3/R6 D=0 N=1
    wr(0, 0); wr(1, 1);
    measure("R6 frame high ticks D=0 N=1", 1);
    // R8 plain mode
    plain8 = 1; wr(0, 10); wr(1, 63);
    measure("R8 frame high ticks plain D=10", 640);
    plain8 = 0;
    // R10 ignored writes
    @(posedge clk); #2; wr_valid = 0; wr_sel = 0; wr_data = 8'd200;
    repeat (300) @(posedge clk);
    #2;
    // R5 fine write mid-frame checked by model
    wr(1, 5);
    // R2 slow tick
    slow = 1; repeat (2000) @(posedge clk);
    #2; slow = 0;
    // R9 standby with write
    standby = 1; wr(0, 77);
    repeat (600) @(posedge clk);
    #2;
    @(negedge clk); chk("R9 pwm_out in standby", pwm_out, 0);
    @(posedge clk); #2; standby = 0;
    repeat (17000) @(posedge clk);
    @(negedge clk);
    cmp_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule